// File: doc/BRIEF.md
# Flash Bank Polling Status Generator

This block sits beside a flash bank and decides what the bank returns on the top bit of its data bus while an embedded program or erase runs. A command port tells it when a program or erase has been accepted. That happens after the last write strobe of a command sequence. The port also carries erase suspend and resume requests. From then on, the block drives a single status bit for every read address. The value depends on the kind of operation in flight. It also depends on whether the read address is the word being programmed, lies in a sector being erased, or lies nowhere relevant.

The embedded algorithm reports completion with a one-cycle done pulse. At that pulse the block returns the bank to array-read mode. A program aimed at a protected sector, or an erase in which every selected sector is protected, never starts the algorithm. For these the block keeps polling alive for a fixed number of clock cycles, then returns to array-read mode on its own. In array-read mode it keeps answering for the last completed operation. The programmed word returns its true status bit, and an erased sector reads 1.

The block produces only the status-bit value over time. The algorithm, the command decoder and the cells themselves live elsewhere.

Top module: `flash_poll_status`

## Requirements
- R1: After reset, and at once while reset is held, `array_mode` is 1, `erase_suspended` is 0 and `poll_bit` is 0 at every address.
- R2: From the cycle after a program command (`cmd_code` 0) is accepted in array mode, `array_mode` is 0. A read at `cmd_addr` returns the inverse of bit 7 of `cmd_data`. Any other read address returns 0. This covers the other words of a buffer page, because `cmd_addr` names the last word of the page.
- R3: A done pulse during a program returns the bank to array mode in the next cycle. From then on, a read at the programmed address returns the true bit 7 of the programmed word.
- R4: While an erase (`cmd_code` 1) runs, `poll_bit` is 0 at every address and `array_mode` is 0.
- R5: A done pulse during an erase returns the bank to array mode in the next cycle. Reads in sectors that were selected and not protected then return 1. Reads in protected sectors and in unselected sectors return 0. The sector is address bits [ADDR_W-1 -: SECT_W], and `cmd_sel`/`prot_map` bit i stands for sector i.
- R6: A suspend (`cmd_code` 2) during a running erase raises `erase_suspended` and makes the erasing sectors read 1. A resume (`cmd_code` 3) returns the bank to the erase and its 0 status.
- R7: A program accepted while the erase is suspended follows the inverted-bit rule of R2. Its done pulse returns the bank to the suspended state, not to array mode.
- R8: A program whose target sector is protected keeps `array_mode` at 0 for exactly PROG_TMO cycles after the accepting edge, with the inverted-bit status at the target. Done pulses are ignored during that time. Afterwards the target reads 0, because nothing was written.
- R9: An erase with no selected, unprotected sector keeps `array_mode` at 0 for exactly ERASE_TMO cycles with `poll_bit` 0. It then returns to array mode with no sector reading 1.
- R10: Commands that do not apply in the current state are ignored. This covers a suspend in array mode and a program while a program runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | One-cycle strobe: command accepted after final write strobe |
| cmd_code | input | 2 | 0 program, 1 erase, 2 suspend, 3 resume |
| cmd_addr | input | ADDR_W | Program target (last word of a buffer page) |
| cmd_data | input | DATA_W | Word being programmed |
| cmd_sel | input | 2**SECT_W | Sectors selected for erase |
| prot_map | input | 2**SECT_W | Sector protection flags |
| op_done | input | 1 | Embedded algorithm completion pulse |
| rd_addr | input | ADDR_W | Address currently being read |
| poll_bit | output | 1 | Status or data value for the top data bit |
| array_mode | output | 1 | Bank is in array-read mode |
| erase_suspended | output | 1 | Erase is suspended (including a program inside the suspend) |

## Verification
The bench uses a partly protected erase to show that only the unprotected selected sectors read 1 afterwards. A design that erased every selected sector would light the protected one. It checks both protect timeouts on the exact last busy cycle and the first free one, which catches an off-by-one counter in either direction. It pulses done inside a protected-program timeout; a design that honoured that pulse would leave early. It reissues a program to the same address with the opposite bit 7 while a program runs; a design that accepted it would flip the status. It also finishes a program inside an erase suspend, where a design that went to array mode would drop the suspended erase.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef enum logic [2:0] {
    ST_ARRAY      = 3'd0,
    ST_PROG       = 3'd1,
    ST_PROG_PROT  = 3'd2,
    ST_ERASE      = 3'd3,
    ST_ERASE_PROT = 3'd4,
    ST_SUSP       = 3'd5,
    ST_SPROG      = 3'd6,
    ST_SPROG_PROT = 3'd7
  } fps_state_e;

  typedef enum logic [1:0] {
    CMD_PROG    = 2'd0,
    CMD_ERASE   = 2'd1,
    CMD_SUSPEND = 2'd2,
    CMD_RESUME  = 2'd3
  } fps_cmd_e;

  typedef enum logic [1:0] {
    RES_NONE  = 2'd0,
    RES_PROG  = 2'd1,
    RES_ERASE = 2'd2
  } fps_res_e;

endpackage

// File: rtl/fps_timer.sv
module fps_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | (run & (|cnt_q));
    cnt_d  = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (run && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = run & (cnt_q == '0);

endmodule

// File: rtl/fps_match.sv
module fps_match #(
  parameter int ADDR_W = 12,
  parameter int SECT_W = 3,
  localparam int NSECT = 1 << SECT_W
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] ref_addr,
  input  logic [NSECT-1:0]  sect_mask,
  output logic              addr_hit,
  output logic              sect_hit
);

  logic [SECT_W-1:0] rd_sect;

  assign rd_sect  = rd_addr[ADDR_W-1 -: SECT_W];
  assign addr_hit = (rd_addr == ref_addr);
  assign sect_hit = sect_mask[rd_sect];

endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
  import fps_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int SECT_W    = 3,
  parameter int PROG_TMO  = 24,
  parameter int ERASE_TMO = 40,
  localparam int NSECT    = 1 << SECT_W,
  localparam int TMAX     = (PROG_TMO > ERASE_TMO) ? PROG_TMO : ERASE_TMO,
  localparam int CNT_W    = $clog2(TMAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_code,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_b7,
  input  logic              tgt_prot,
  input  logic [NSECT-1:0]  cmd_sel,
  input  logic [NSECT-1:0]  prot_map,
  input  logic              op_done,
  input  logic              tmr_expired,
  output fps_state_e        state,
  output logic [ADDR_W-1:0] prog_addr,
  output logic              prog_b7,
  output logic [NSECT-1:0]  erase_set,
  output fps_res_e          last_res,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val
);

  localparam logic [CNT_W-1:0] P_LOAD = CNT_W'(PROG_TMO - 1);
  localparam logic [CNT_W-1:0] E_LOAD = CNT_W'(ERASE_TMO - 1);

  fps_state_e        st_q, st_d;
  fps_res_e          res_q, res_d;
  logic [ADDR_W-1:0] paddr_q;
  logic              pb7_q;
  logic [NSECT-1:0]  eff_q, eff_d;
  logic              prog_cap, erase_cap, res_en;
  logic              prog_cmd, erase_cmd, sus_cmd, res_cmd;

  assign prog_cmd  = cmd_valid && (cmd_code == CMD_PROG);
  assign erase_cmd = cmd_valid && (cmd_code == CMD_ERASE);
  assign sus_cmd   = cmd_valid && (cmd_code == CMD_SUSPEND);
  assign res_cmd   = cmd_valid && (cmd_code == CMD_RESUME);
  assign eff_d     = cmd_sel & ~prot_map;

  // next-state process
  always_comb begin
    st_d      = st_q;
    res_d     = res_q;
    prog_cap  = 1'b0;
    erase_cap = 1'b0;
    res_en    = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    unique case (st_q)
      ST_ARRAY: begin
        if (prog_cmd) begin
          prog_cap = 1'b1;
          res_en   = 1'b1;
          res_d    = RES_NONE;
          if (tgt_prot) begin
            st_d     = ST_PROG_PROT;
            tmr_load = 1'b1;
            tmr_val  = P_LOAD;
          end else begin
            st_d = ST_PROG;
          end
        end else if (erase_cmd) begin
          erase_cap = 1'b1;
          res_en    = 1'b1;
          res_d     = RES_NONE;
          if (eff_d == '0) begin
            st_d     = ST_ERASE_PROT;
            tmr_load = 1'b1;
            tmr_val  = E_LOAD;
          end else begin
            st_d = ST_ERASE;
          end
        end
      end
      ST_PROG: begin
        if (op_done) begin
          st_d   = ST_ARRAY;
          res_en = 1'b1;
          res_d  = RES_PROG;
        end
      end
      ST_PROG_PROT: begin
        if (tmr_expired) begin
          st_d   = ST_ARRAY;
          res_en = 1'b1;
          res_d  = RES_NONE;
        end
      end
      ST_ERASE: begin
        if (op_done) begin
          st_d   = ST_ARRAY;
          res_en = 1'b1;
          res_d  = RES_ERASE;
        end else if (sus_cmd) begin
          st_d = ST_SUSP;
        end
      end
      ST_ERASE_PROT: begin
        if (tmr_expired) begin
          st_d   = ST_ARRAY;
          res_en = 1'b1;
          res_d  = RES_NONE;
        end
      end
      ST_SUSP: begin
        if (res_cmd) begin
          st_d = ST_ERASE;
        end else if (prog_cmd) begin
          prog_cap = 1'b1;
          if (tgt_prot) begin
            st_d     = ST_SPROG_PROT;
            tmr_load = 1'b1;
            tmr_val  = P_LOAD;
          end else begin
            st_d = ST_SPROG;
          end
        end
      end
      ST_SPROG: begin
        if (op_done) st_d = ST_SUSP;
      end
      ST_SPROG_PROT: begin
        if (tmr_expired) st_d = ST_SUSP;
      end
      default: st_d = ST_ARRAY;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_ARRAY;
      res_q   <= RES_NONE;
      paddr_q <= '0;
      pb7_q   <= 1'b0;
      eff_q   <= '0;
    end else begin
      st_q <= st_d;
      if (res_en) res_q <= res_d;
      if (prog_cap) begin
        paddr_q <= cmd_addr;
        pb7_q   <= cmd_b7;
      end
      if (erase_cap) eff_q <= eff_d;
    end
  end

  assign state     = st_q;
  assign prog_addr = paddr_q;
  assign prog_b7   = pb7_q;
  assign erase_set = eff_q;
  assign last_res  = res_q;

endmodule

// File: rtl/fps_status.sv
module fps_status
  import fps_pkg::*;
(
  input  fps_state_e state,
  input  fps_res_e   last_res,
  input  logic       prog_b7,
  input  logic       addr_hit,
  input  logic       sect_hit,
  output logic       poll_bit
);

  always_comb begin
    poll_bit = 1'b0;
    unique case (state)
      ST_ARRAY: begin
        if (last_res == RES_PROG && addr_hit) begin
          poll_bit = prog_b7;
        end else if (last_res == RES_ERASE) begin
          poll_bit = sect_hit;
        end
      end
      ST_PROG, ST_PROG_PROT:       poll_bit = addr_hit & ~prog_b7;
      ST_ERASE, ST_ERASE_PROT:     poll_bit = 1'b0;
      ST_SUSP:                     poll_bit = sect_hit;
      ST_SPROG, ST_SPROG_PROT:     poll_bit = addr_hit ? ~prog_b7 : sect_hit;
      default:                     poll_bit = 1'b0;
    endcase
  end

endmodule

// File: rtl/flash_poll_status.sv
module flash_poll_status
  import fps_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 16,
  parameter int SECT_W    = 3,
  parameter int STAT_BIT  = 7,
  parameter int PROG_TMO  = 24,
  parameter int ERASE_TMO = 40,
  localparam int NSECT    = 1 << SECT_W,
  localparam int TMAX     = (PROG_TMO > ERASE_TMO) ? PROG_TMO : ERASE_TMO,
  localparam int CNT_W    = $clog2(TMAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_code,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [NSECT-1:0]  cmd_sel,
  input  logic [NSECT-1:0]  prot_map,
  input  logic              op_done,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              poll_bit,
  output logic              array_mode,
  output logic              erase_suspended
);

  logic [1:0]        rst_sync_q;
  logic              rst_s;
  fps_state_e        state;
  fps_res_e          last_res;
  logic [ADDR_W-1:0] prog_addr;
  logic              prog_b7;
  logic [NSECT-1:0]  erase_set;
  logic              tmr_load, tmr_expired, tmr_run;
  logic [CNT_W-1:0]  tmr_val;
  logic              addr_hit, sect_hit, tgt_prot;
  logic              unused_data;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  assign tgt_prot    = prot_map[cmd_addr[ADDR_W-1 -: SECT_W]];
  assign unused_data = ^cmd_data;

  fps_ctrl #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W),
    .PROG_TMO(PROG_TMO), .ERASE_TMO(ERASE_TMO)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_s),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
    .cmd_b7(cmd_data[STAT_BIT]), .tgt_prot(tgt_prot),
    .cmd_sel(cmd_sel), .prot_map(prot_map), .op_done(op_done),
    .tmr_expired(tmr_expired),
    .state(state), .prog_addr(prog_addr), .prog_b7(prog_b7),
    .erase_set(erase_set), .last_res(last_res),
    .tmr_load(tmr_load), .tmr_val(tmr_val)
  );

  assign tmr_run = (state == ST_PROG_PROT) || (state == ST_ERASE_PROT) ||
                   (state == ST_SPROG_PROT);

  fps_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_s),
    .load(tmr_load), .load_val(tmr_val), .run(tmr_run),
    .expired(tmr_expired)
  );

  fps_match #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_match (
    .rd_addr(rd_addr), .ref_addr(prog_addr), .sect_mask(erase_set),
    .addr_hit(addr_hit), .sect_hit(sect_hit)
  );

  fps_status u_status (
    .state(state), .last_res(last_res), .prog_b7(prog_b7),
    .addr_hit(addr_hit), .sect_hit(sect_hit), .poll_bit(poll_bit)
  );

  assign array_mode      = (state == ST_ARRAY);
  assign erase_suspended = (state == ST_SUSP) || (state == ST_SPROG) ||
                           (state == ST_SPROG_PROT);

endmodule

// File: rtl/fps_checker.sv
module fps_checker
  import fps_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int PROG_TMO  = 24,
  parameter int ERASE_TMO = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [1:0]        cmd_code,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              cmd_b7,
  input logic              op_done,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              poll_bit,
  input logic              array_mode,
  input logic              erase_suspended,
  input fps_state_e        state
);

  localparam int CK_W = 16;
  localparam logic [CK_W-1:0] P_LAST = CK_W'(PROG_TMO - 1);
  localparam logic [CK_W-1:0] E_LAST = CK_W'(ERASE_TMO - 1);

  logic [ADDR_W-1:0] m_addr;
  logic              m_b7;
  logic [CK_W-1:0]   pck, eck;
  logic              in_prog;

  assign in_prog = (state == ST_PROG) || (state == ST_PROG_PROT) ||
                   (state == ST_SPROG) || (state == ST_SPROG_PROT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_addr <= '0;
      m_b7   <= 1'b0;
      pck    <= '0;
      eck    <= '0;
    end else begin
      if (((state == ST_ARRAY) || (state == ST_SUSP)) && cmd_valid &&
          (cmd_code == CMD_PROG)) begin
        m_addr <= cmd_addr;
        m_b7   <= cmd_b7;
      end
      pck <= (state == ST_PROG_PROT)  ? pck + 1'b1 : '0;
      eck <= (state == ST_ERASE_PROT) ? eck + 1'b1 : '0;
    end
  end

  AST_PROG_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_prog && rd_addr == m_addr) |-> (poll_bit == ~m_b7)); // R2
  AST_PROG_DONE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROG && op_done) |=> array_mode); // R3
  AST_ERASE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ERASE) |-> !poll_bit); // R4
  AST_SUSP_NOT_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    erase_suspended |-> !array_mode); // R6
  AST_SPROG_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SPROG && op_done) |=> erase_suspended); // R7
  AST_PTMO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROG_PROT && pck < P_LAST) |=> (state == ST_PROG_PROT)); // R8
  AST_PTMO_END: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROG_PROT && pck == P_LAST) |=> array_mode); // R8
  AST_ETMO_END: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ERASE_PROT && eck == E_LAST) |=> array_mode); // R9
  AST_ETMO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ERASE_PROT) |-> (!poll_bit && !array_mode)); // R9

endmodule

bind flash_poll_status fps_checker #(
  .ADDR_W(ADDR_W), .PROG_TMO(PROG_TMO), .ERASE_TMO(ERASE_TMO)
) u_chk (
  .clk(clk), .rst_n(rst_s),
  .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
  .cmd_b7(cmd_data[STAT_BIT]), .op_done(op_done), .rd_addr(rd_addr),
  .poll_bit(poll_bit), .array_mode(array_mode),
  .erase_suspended(erase_suspended), .state(state)
);

// File: tb/flash_poll_status_test.sv
`timescale 1ns/1ps
module flash_poll_status_test;

  localparam int PT = 24;
  localparam int ET = 40;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [1:0]  cmd_code;
  logic [11:0] cmd_addr;
  logic [15:0] cmd_data;
  logic [7:0]  cmd_sel;
  logic [7:0]  prot_map;
  logic        op_done;
  logic [11:0] rd_addr;
  logic        poll_bit, array_mode, erase_suspended;

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    finished = 1'b0;
  logic [2:0] sb_exp[$];
  string      sb_req[$];

  always #2.5 clk = ~clk;

  flash_poll_status #(.PROG_TMO(PT), .ERASE_TMO(ET)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_sel(cmd_sel),
    .prot_map(prot_map), .op_done(op_done), .rd_addr(rd_addr),
    .poll_bit(poll_bit), .array_mode(array_mode),
    .erase_suspended(erase_suspended)
  );

  // driver: set read address, push expected {poll, array, suspended}
  task automatic expect_rd(input logic [11:0] a, input logic p,
                           input logic am, input logic su, input string req);
    @(negedge clk);
    rd_addr = a;
    sb_exp.push_back({p, am, su});
    sb_req.push_back(req);
  endtask

  task automatic send(input logic [1:0] code, input logic [11:0] a,
                      input logic [15:0] d, input logic [7:0] sel);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; cmd_addr = a; cmd_data = d; cmd_sel = sel;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
  endtask

  // monitor: compare outputs shortly after each negedge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_exp.size() > 0) begin
        logic [2:0] e;
        string r;
        e = sb_exp.pop_front();
        r = sb_req.pop_front();
        n_checks++;
        if ({poll_bit, array_mode, erase_suspended} !== e) begin
          n_fails++;
          $display("FAIL %s: addr %h actual poll/array/susp=%b expected %b",
                   r, rd_addr, {poll_bit, array_mode, erase_suspended}, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_code = 2'd0; cmd_addr = '0;
    cmd_data = '0; cmd_sel = '0; prot_map = 8'b0010_0000; op_done = 1'b0;
    rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    expect_rd(12'h000, 0, 1, 0, "R1 reset state");
    send(2'd2, 12'h000, 16'h0000, 8'h00);
    expect_rd(12'h000, 0, 1, 0, "R10 suspend in array mode ignored");

    // program, bit7 = 1
    send(2'd0, 12'h123, 16'h0080, 8'h00);
    expect_rd(12'h123, 0, 0, 0, "R2 inverted bit at target");
    send(2'd0, 12'h123, 16'h0000, 8'h00);
    expect_rd(12'h123, 0, 0, 0, "R10 program during program ignored");
    pulse_done();
    expect_rd(12'h123, 1, 1, 0, "R3 true bit after done");

    // program, bit7 = 0
    send(2'd0, 12'h345, 16'h007F, 8'h00);
    expect_rd(12'h345, 1, 0, 0, "R2 inverted bit at last buffer word");
    expect_rd(12'h344, 0, 0, 0, "R2 other buffer word reads 0");
    pulse_done();
    expect_rd(12'h345, 0, 1, 0, "R3 true bit 0 after done");

    // erase sectors 1,2,5 with 5 protected
    send(2'd1, 12'h000, 16'h0000, 8'b0010_0110);
    expect_rd(12'h200, 0, 0, 0, "R4 erase running reads 0");
    send(2'd2, 12'h000, 16'h0000, 8'h00);
    expect_rd(12'h200, 1, 0, 1, "R6 suspended erase sector reads 1");
    expect_rd(12'h400, 1, 0, 1, "R6 second erase sector reads 1");
    expect_rd(12'hA00, 0, 0, 1, "R6 protected sector not erasing");
    send(2'd0, 12'h010, 16'h0000, 8'h00);
    expect_rd(12'h010, 1, 0, 1, "R7 program inside suspend inverted");
    pulse_done();
    expect_rd(12'h010, 0, 0, 1, "R7 done returns to suspend");
    send(2'd3, 12'h000, 16'h0000, 8'h00);
    expect_rd(12'h200, 0, 0, 0, "R6 resume back to erase");
    pulse_done();
    expect_rd(12'h200, 1, 1, 0, "R5 erased sector reads 1");
    expect_rd(12'h400, 1, 1, 0, "R5 second erased sector reads 1");
    expect_rd(12'hA00, 0, 1, 0, "R5 protected sector not erased");
    expect_rd(12'h000, 0, 1, 0, "R5 unselected sector reads 0");

    // protected program timeout
    send(2'd0, 12'hA10, 16'h0000, 8'h00);
    repeat (PT - 2) @(negedge clk);
    expect_rd(12'hA10, 1, 0, 0, "R8 last busy cycle");
    expect_rd(12'hA10, 0, 1, 0, "R8 back to array, unchanged");

    // protected program ignores done
    send(2'd0, 12'hA10, 16'h0000, 8'h00);
    pulse_done();
    expect_rd(12'hA10, 1, 0, 0, "R8 done ignored during timeout");
    repeat (PT + 4) @(negedge clk);
    expect_rd(12'hA10, 0, 1, 0, "R8 timeout ends after done pulse");

    // all-protected erase
    send(2'd1, 12'h000, 16'h0000, 8'b0010_0000);
    expect_rd(12'hA00, 0, 0, 0, "R9 protected erase polling");
    repeat (ET - 3) @(negedge clk);
    expect_rd(12'hA00, 0, 0, 0, "R9 last busy cycle");
    expect_rd(12'hA00, 0, 1, 0, "R9 back to array, nothing erased");

    // reset in the middle of a program
    send(2'd0, 12'h055, 16'h0000, 8'h00);
    @(negedge clk);
    rst_n = 1'b0;
    expect_rd(12'h055, 0, 1, 0, "R1 reset aborts program");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule